// File: doc/BRIEF.md
# Serial Link Power-Down Controller

This block sits on the codec side of a five-wire audio serial link and controls when the link's bit clock runs. When the register decoder reports a write that sets the interface power-down bit, the block stops the bit clock at the end of a complete high phase and puts the link to sleep. The decoder raises that event only after the control address and data slots of the frame have arrived. During sleep, the controller holds the sync and serial data lines low. The block only exits sleep on one of two events: a warm wake, which is a clean high pulse on the sync line, or a cold reset on the active-low reset pin.

The bit clock is absent during sleep, so the sync line is sampled through a synchronizer clocked by the free-running master clock. A warm wake is accepted only after sync has been seen high for a minimum number of master-clock samples and then returns low. On that release, the block emits a one-cycle pulse that clears only the link power-down bit; every other register keeps its value. After a programmable release delay, the bit clock restarts. It always begins with a full low phase, and frame alignment resumes at the next sync. A cold reset returns the block straight to the running state without emitting the clear pulse, because the register file is reset by the same pin.

Top module: `link_pwrdn_ctrl`

## Requirements
- R1: While `cold_rst_n` is low at a clock edge, the outputs are `bitclk_en`=1, `bitclk_o`=0 and `pd_clr`=0. After release, the first rise of `bitclk_o` comes HALF_PER master cycles after the first non-reset edge, counting that edge.
- R2: While running, `bitclk_o` toggles every HALF_PER master cycles, giving a period of 2*HALF_PER.
- R3: A cycle with `pd_wr_en`=1 and `pd_wr_bit`=1 while running drives `bitclk_en` to 0 on the next cycle. `bitclk_o` finishes any high phase in progress and then stays low for the whole sleep.
- R4: A write event with `pd_wr_bit`=0, or `pd_wr_bit`=1 without `pd_wr_en`, leaves the link running.
- R5: During sleep, a warm wake is accepted when `sync_in` is high for at least MIN_WARM consecutive master cycles and then falls. A shorter high pulse is ignored, and the link stays asleep.
- R6: Each accepted warm wake produces exactly one `pd_clr` pulse, one cycle long.
- R7: `bitclk_en` returns to 1 exactly WAKE_DLY cycles after `pd_clr` rises. `pd_clr` is never high while `bitclk_en` is high.
- R8: After a wake, `bitclk_o` is low when `bitclk_en` rises and rises HALF_PER cycles later.
- R9: Activity on `sync_in` while the link runs produces no `pd_clr` and leaves the clock running.
- R10: A cold reset during sleep restarts the link with `bitclk_en`=1 and produces no `pd_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| cold_rst_n | input | 1 | Cold reset, active low, sampled synchronously |
| pd_wr_en | input | 1 | One-cycle decoded write to the power-down register |
| pd_wr_bit | input | 1 | Value written to the link power-down bit |
| sync_in | input | 1 | Serial-link sync line, asynchronous while asleep |
| bitclk_en | output | 1 | High while the bit clock is allowed to run |
| bitclk_o | output | 1 | Generated bit clock |
| pd_clr | output | 1 | One-cycle pulse that clears the link power-down bit |

## Verification
The hardest situation to reach from the ports is a sync pulse that sits exactly on the acceptance boundary during sleep. Before the boundary is tested, the link has to be driven into sleep through a genuine power-down write, and the clock has to be allowed to finish its high phase. The stimulus first sends a pulse one cycle shorter than MIN_WARM and confirms the link stays asleep with no clear pulse. It then sends a pulse of exactly MIN_WARM cycles and measures the cycle distances from the clear pulse to re-enable, and from re-enable to the first clock rise. A further sleep entry is then ended by cold reset instead of a warm wake.

// File: rtl/lpd_pkg.sv
// Package: shared types for the serial link power-down controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lpd_pkg;

    // Link state: clock running, clock halted, or waiting out the release delay.
    typedef enum logic [1:0] {
        LNK_RUN   = 2'd0,
        LNK_SLEEP = 2'd1,
        LNK_WAKE  = 2'd2
    } lnk_state_t;

endpackage

// File: rtl/lpd_sync.sv
// Module: lpd_sync
// A multi-stage flip-flop synchronizer that brings an asynchronous level
// into the master-clock domain.
// Assumes: the input is a level held for several master cycles; STAGES >= 2.
module lpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lpd_warm_detect.sv
// Module: lpd_warm_detect
// Qualifies a warm wake. The synchronized sync level must stay high for
// MIN_WARM consecutive samples while the detector is armed. The wake is
// reported in the cycle where the level is seen low again (the release).
// Assumes: sync_s is already synchronous to clk; armed is high only in sleep.
module lpd_warm_detect #(
    parameter int MIN_WARM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic sync_s,
    output logic wake
);

    localparam int HW = $clog2(MIN_WARM + 1);
    localparam logic [HW-1:0] HMAX = HW'(MIN_WARM);

    logic [HW-1:0] high_q;

    // Count consecutive high samples while armed, saturating at MIN_WARM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= '0;
        end else if (!armed || !sync_s) begin
            high_q <= '0;
        end else if (high_q != HMAX) begin
            high_q <= high_q + 1'b1;
        end
    end

    // Wake on release after a sufficiently long high level.
    always_comb begin
        wake = armed && !sync_s && (high_q == HMAX);
    end

endmodule

// File: rtl/lpd_bitclk_gen.sv
// Module: lpd_bitclk_gen
// Divides the master clock to form the bit clock, with a half period of
// HALF_PER master cycles. When run drops, any high phase in progress is
// completed and the output then parks low with the phase counter cleared,
// so a restart always begins with a full low phase.
// Assumes: HALF_PER >= 1.
module lpd_bitclk_gen #(
    parameter int HALF_PER = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bitclk
);

    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          advance;

    // Keep counting while running, or while finishing a high phase.
    always_comb begin
        advance = run || lvl_q;
    end

    // Phase counter and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!advance) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= !lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bitclk = lvl_q;

endmodule

// File: rtl/link_pwrdn_ctrl.sv
// Module: link_pwrdn_ctrl (top)
// Codec-side controller for the serial link's low-power state. A decoded
// write that sets the link power-down bit halts the bit clock. In sleep, a
// qualified high pulse on sync (warm wake) emits a one-cycle clear for that
// bit, and the clock restarts after WAKE_DLY cycles. Cold reset on
// cold_rst_n returns directly to the running state.
// Assumes: pd_wr_en is raised by the register decoder once the frame's
// address and data slots are complete; mclk keeps running during sleep.
module link_pwrdn_ctrl
    import lpd_pkg::*;
#(
    parameter int HALF_PER    = 2,
    parameter int MIN_WARM    = 2,
    parameter int WAKE_DLY    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic cold_rst_n,
    input  logic pd_wr_en,
    input  logic pd_wr_bit,
    input  logic sync_in,
    output logic bitclk_en,
    output logic bitclk_o,
    output logic pd_clr
);

    localparam int DW = (WAKE_DLY > 1) ? $clog2(WAKE_DLY) : 1;
    localparam logic [DW-1:0] DLY_LAST = DW'(WAKE_DLY - 1);

    lnk_state_t    state_q;
    logic [DW-1:0] dly_q;
    logic          clr_q;
    logic          sync_s;
    logic          wake;
    logic          armed;
    logic          halt_req;

    lpd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (mclk),
        .rst_n   (cold_rst_n),
        .async_i (sync_in),
        .sync_o  (sync_s)
    );

    lpd_warm_detect #(.MIN_WARM(MIN_WARM)) warm_i (
        .clk    (mclk),
        .rst_n  (cold_rst_n),
        .armed  (armed),
        .sync_s (sync_s),
        .wake   (wake)
    );

    lpd_bitclk_gen #(.HALF_PER(HALF_PER)) clkgen_i (
        .clk    (mclk),
        .rst_n  (cold_rst_n),
        .run    (bitclk_en),
        .bitclk (bitclk_o)
    );

    // Decode the state into the enable, the detector arm, and the halt request.
    always_comb begin
        bitclk_en = (state_q == LNK_RUN);
        armed     = (state_q == LNK_SLEEP);
        halt_req  = pd_wr_en && pd_wr_bit;
    end

    // Link state machine and release-delay counter.
    always_ff @(posedge mclk) begin
        if (!cold_rst_n) begin
            state_q <= LNK_RUN;
            dly_q   <= '0;
        end else begin
            unique case (state_q)
                LNK_RUN: begin
                    if (halt_req) begin
                        state_q <= LNK_SLEEP;
                    end
                end
                LNK_SLEEP: begin
                    if (wake) begin
                        state_q <= LNK_WAKE;
                        dly_q   <= '0;
                    end
                end
                LNK_WAKE: begin
                    if (dly_q == DLY_LAST) begin
                        state_q <= LNK_RUN;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= LNK_RUN;
                end
            endcase
        end
    end

    // One-cycle clear pulse for the link power-down bit on each warm wake.
    always_ff @(posedge mclk) begin
        if (!cold_rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= wake;
        end
    end

    assign pd_clr = clr_q;

endmodule

// File: rtl/link_pwrdn_ctrl_chk.sv
// Module: link_pwrdn_ctrl_chk
// Port-level assertions for link_pwrdn_ctrl, attached with bind below.
// Assumes: cold_rst_n is held low from time zero for at least one edge.
module link_pwrdn_ctrl_chk #(
    parameter int WAKE_DLY = 6
) (
    input logic mclk,
    input logic cold_rst_n,
    input logic pd_wr_en,
    input logic pd_wr_bit,
    input logic bitclk_en,
    input logic bitclk_o,
    input logic pd_clr
);

    logic [31:0] since_clr_q;

    // Count cycles from a clear pulse until the clock is re-enabled.
    always_ff @(posedge mclk) begin
        if (!cold_rst_n) begin
            since_clr_q <= '0;
        end else if (pd_clr) begin
            since_clr_q <= 32'd1;
        end else if (bitclk_en) begin
            since_clr_q <= '0;
        end else if (since_clr_q != 0) begin
            since_clr_q <= since_clr_q + 32'd1;
        end
    end

    // R3
    halt_on_write_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        (bitclk_en && pd_wr_en && pd_wr_bit) |=> !bitclk_en);

    // R3
    parked_low_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        (!bitclk_en && !bitclk_o) |=> !bitclk_o);

    // R6
    clr_single_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        pd_clr |=> !pd_clr);

    // R7
    clr_while_halted_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        pd_clr |-> !bitclk_en);

    // R7
    release_delay_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        ($rose(bitclk_en) && since_clr_q != 0) |-> (since_clr_q == 32'(WAKE_DLY)));

    // R8
    restart_low_chk: assert property (@(posedge mclk) disable iff (!cold_rst_n)
        $rose(bitclk_en) |-> !bitclk_o);

endmodule

bind link_pwrdn_ctrl link_pwrdn_ctrl_chk #(.WAKE_DLY(WAKE_DLY)) chk_i (
    .mclk       (mclk),
    .cold_rst_n (cold_rst_n),
    .pd_wr_en   (pd_wr_en),
    .pd_wr_bit  (pd_wr_bit),
    .bitclk_en  (bitclk_en),
    .bitclk_o   (bitclk_o),
    .pd_clr     (pd_clr)
);

// File: tb/link_pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_pwrdn_ctrl_tb_top;

    localparam int HALF_PER = 2;
    localparam int MIN_WARM = 2;
    localparam int WAKE_DLY = 6;
    localparam int WDOG     = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en;
    logic wr_bit;
    logic sync_l;
    logic bitclk_en;
    logic bitclk_o;
    logic pd_clr;

    int checks = 0;
    int fails  = 0;
    int clr_cnt = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state.
    int m_st = 0;
    int m_high = 0;
    int m_tick = 0;
    int m_dly = 0;
    bit m_lvl = 0;
    bit m_clr = 0;
    bit m_q[$] = '{1'b0, 1'b0};

    always #2 clk = ~clk;

    link_pwrdn_ctrl #(
        .HALF_PER (HALF_PER),
        .MIN_WARM (MIN_WARM),
        .WAKE_DLY (WAKE_DLY)
    ) dut_i (
        .mclk       (clk),
        .cold_rst_n (rst_n),
        .pd_wr_en   (wr_en),
        .pd_wr_bit  (wr_bit),
        .sync_in    (sync_l),
        .bitclk_en  (bitclk_en),
        .bitclk_o   (bitclk_o),
        .pd_clr     (pd_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_high = 0; m_tick = 0; m_dly = 0;
            m_lvl = 0; m_clr = 0;
            m_q = '{1'b0, 1'b0};
        end else begin
            int  old_st;
            bit  seen;
            bit  wake;
            old_st = m_st;
            seen = m_q[0];
            void'(m_q.pop_front());
            m_q.push_back(sync_l);
            wake = (old_st == 1) && !seen && (m_high >= MIN_WARM);
            m_high = (old_st == 1 && seen) ? m_high + 1 : 0;
            m_clr = wake;
            if (old_st == 0 || m_lvl) begin
                m_tick++;
                if (m_tick == HALF_PER) begin
                    m_tick = 0;
                    m_lvl = !m_lvl;
                end
            end else begin
                m_tick = 0;
            end
            if (old_st == 0) begin
                if (wr_en && wr_bit) m_st = 1;
            end else if (old_st == 1) begin
                if (wake) begin m_st = 2; m_dly = 0; end
            end else begin
                if (m_dly == WAKE_DLY - 1) m_st = 0;
                else m_dly++;
            end
        end
    end

    // Compare against the model, count clear pulses, and run the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (started && !done) begin
            chk("R3 bitclk_en vs model", int'(bitclk_en), int'(m_st == 0));
            chk("R2 bitclk_o vs model", int'(bitclk_o), int'(m_lvl));
            chk("R6 pd_clr vs model", int'(pd_clr), int'(m_clr));
        end
        if (pd_clr) clr_cnt++;
        if (cycles > WDOG && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        int n;
        int c0;
        int hi;
        rst_n = 1'b0; wr_en = 1'b0; wr_bit = 1'b0; sync_l = 1'b0;
        cyc(5);
        // R1: reset state
        chk("R1 bitclk_en in reset", int'(bitclk_en), 1);
        chk("R1 bitclk_o in reset", int'(bitclk_o), 0);
        chk("R1 pd_clr in reset", int'(pd_clr), 0);
        rst_n = 1'b1;
        n = 0;
        while (!bitclk_o && n < 50) begin cyc(1); n++; end
        chk("R1 first rise after release", n, HALF_PER);
        cyc(20);

        // R4: writes that must not halt
        wr_en = 1'b1; wr_bit = 1'b0; cyc(1);
        wr_en = 1'b0; wr_bit = 1'b1; cyc(1);
        wr_bit = 1'b0; cyc(6);
        chk("R4 still running", int'(bitclk_en), 1);

        // R9: sync activity while running
        c0 = clr_cnt;
        sync_l = 1'b1; cyc(4); sync_l = 1'b0; cyc(8);
        chk("R9 no clear while running", clr_cnt - c0, 0);
        chk("R9 clock still enabled", int'(bitclk_en), 1);

        // R3: halt on power-down write
        wr_en = 1'b1; wr_bit = 1'b1; cyc(1);
        wr_en = 1'b0; wr_bit = 1'b0;
        chk("R3 enable dropped", int'(bitclk_en), 0);
        cyc(2 * HALF_PER + 2);
        hi = 0;
        repeat (12) begin cyc(1); if (bitclk_o) hi++; end
        chk("R3 clock parked low", hi, 0);

        // R5: glitch shorter than MIN_WARM is ignored
        c0 = clr_cnt;
        sync_l = 1'b1; cyc(MIN_WARM - 1); sync_l = 1'b0; cyc(10);
        chk("R5 glitch no clear", clr_cnt - c0, 0);
        chk("R5 glitch stays asleep", int'(bitclk_en), 0);

        // R5, R6, R7, R8: exact minimum pulse wakes the link
        c0 = clr_cnt;
        sync_l = 1'b1; cyc(MIN_WARM); sync_l = 1'b0;
        n = 0;
        while (!pd_clr && n < 40) begin cyc(1); n++; end
        chk("R5 minimum pulse accepted", int'(pd_clr), 1);
        n = 0;
        while (!bitclk_en && n < 100) begin cyc(1); n++; end
        chk("R7 release delay", n, WAKE_DLY);
        chk("R8 low at restart", int'(bitclk_o), 0);
        n = 0;
        while (!bitclk_o && n < 100) begin cyc(1); n++; end
        chk("R8 full low phase", n, HALF_PER);
        cyc(4);
        chk("R6 single clear pulse", clr_cnt - c0, 1);

        // R5: a long pulse also wakes
        cyc(10);
        wr_en = 1'b1; wr_bit = 1'b1; cyc(1); wr_en = 1'b0; wr_bit = 1'b0;
        cyc(10);
        c0 = clr_cnt;
        sync_l = 1'b1; cyc(7); sync_l = 1'b0;
        cyc(WAKE_DLY + 10);
        chk("R5 long pulse clear", clr_cnt - c0, 1);
        chk("R5 long pulse running", int'(bitclk_en), 1);

        // R10: cold reset during sleep
        wr_en = 1'b1; wr_bit = 1'b1; cyc(1); wr_en = 1'b0; wr_bit = 1'b0;
        cyc(10);
        chk("R10 asleep before reset", int'(bitclk_en), 0);
        c0 = clr_cnt;
        rst_n = 1'b0; cyc(3);
        chk("R10 enabled in reset", int'(bitclk_en), 1);
        rst_n = 1'b1; cyc(10);
        chk("R10 no clear on cold reset", clr_cnt - c0, 0);
        chk("R10 running after reset", int'(bitclk_en), 1);

        cyc(4);
        finish_run();
    end

endmodule